// File: doc/BRIEF.md
# Zero-Overhead Loop Program Sequencer

This block produces the program fetch address for a small processor core, one address per clock. Each cycle it receives an already-decoded operation type for the instruction at the current address, together with a branch target, the result of the condition test, and, for a loop-start operation, the last address of the loop body and an iteration count. From these it chooses the next address: the following location, a branch target, a saved return address, or the first address of a running loop.

Subroutine linkage uses a return-address stack. Hardware loops use a second stack that holds the first address, last address and remaining count of each active loop. When the fetch address reaches the last address of the innermost loop, the sequencer goes back to the first address of that loop by itself. No branch instruction closes the loop, so the loop adds no cycles. Loops can be nested up to the depth of the loop stack. Overflow and underflow of either stack set sticky flags, which only reset clears.

Top module: `zol_sequencer`

## Requirements
- R1: While reset is active and on the first cycle after it, the fetch address is 0, both flags are low and both stacks are empty.
- R2: Operation codes are 0 sequential, 1 jump, 2 call, 3 return, 4 loop start. Codes 5 to 7 behave as code 0. A sequential operation that is not at the end of an active loop gives the current address plus 1 on the next cycle.
- R3: A jump whose condition input is high gives the target address on the next cycle. With the condition low it gives the current address plus 1.
- R4: A call whose condition is high gives the target on the next cycle and saves the current address plus 1. A call whose condition is low gives the current address plus 1 and saves nothing. A return gives the most recently saved address on the next cycle and removes it from the stack, so nested calls unwind in reverse order.
- R5: A loop start saves the current address plus 1 as the loop's first address, together with the supplied last address and count, and continues at the current address plus 1.
- R6: On a sequential operation at the innermost loop's last address with a count above 1, the next address is the loop's first address and the count drops by 1. With a count of 1 or 0 the loop entry is removed and the address advances by 1. The body therefore runs max(count,1) times with no extra cycles.
- R7: Nested loops close independently. The inner loop completes all of its passes and is removed before the outer loop's end test applies again, and the outer count is unaffected by the inner loop.
- R8: The return-address stack holds 16 entries. A taken call while it is full sets the overflow flag, still goes to the target, and leaves the stored entries intact. The flag stays high until reset.
- R9: A return with an empty return-address stack sets the underflow flag and advances to the current address plus 1. The flag stays high until reset.
- R10: The loop stack holds 4 entries. A loop start while it is full sets the overflow flag and pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Decoded operation type of the current instruction |
| cond_i | input | 1 | Condition result for jump and call |
| target_i | input | 14 | Branch or call target address |
| loop_end_i | input | 14 | Last body address for a loop start |
| loop_cnt_i | input | 14 | Iteration count for a loop start |
| fetch_addr_o | output | 14 | Current program fetch address |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The bench sweeps loop counts 1 to 4 against body lengths 1 to 3 and compares every fetch address with the arithmetic pattern. A design with an off-by-one in the count test would run one pass too many or too few, and one that closed loops with a bubble would repeat or skip an address. A count of zero, a two-level nest in which the inner body is a single instruction at its own end address, and calls nested two deep are replayed cycle by cycle. Overflow is provoked on the 17th call and the 5th loop start, and underflow with a return on an empty stack. These cases catch flags that are not sticky, a push that overwrites the top when the stack is full, and a branch that is lost when the stack overflows.

// File: rtl/zol_pkg.sv
package zol_pkg;

  typedef enum logic [2:0] {
    OP_SEQ   = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_LOOP  = 3'd4
  } seq_op_e;

endpackage

// File: rtl/zol_lifo.sv
module zol_lifo #(
  parameter int W     = 14,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         wr_top_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [PW-1:0] cnt_q;
  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] top_idx;
  logic [IW-1:0] push_idx;

  assign top_idx  = IW'(cnt_q - PW'(1));
  assign push_idx = IW'(cnt_q);
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == PW'(DEPTH));
  assign top_o    = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[push_idx] <= data_i;
      cnt_q           <= cnt_q + PW'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - PW'(1);
    end else if (wr_top_i && !empty_o) begin
      mem_q[top_idx] <= data_i;
    end
  end

  // R8 / R10: occupancy never exceeds the configured depth
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PW'(DEPTH));

  // R4: an accepted push grows the stack by exactly one entry
  a_r4_push_count: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && push_i && !full_o |=> cnt_q == $past(cnt_q) + PW'(1));

  // R4: an accepted pop shrinks the stack by exactly one entry
  a_r4_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !push_i && pop_i && !empty_o |=> cnt_q == $past(cnt_q) - PW'(1));

endmodule

// File: rtl/zol_next_addr.sv
module zol_next_addr
  import zol_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 14
) (
  input  seq_op_e           op,
  input  logic              cond,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] ret_top,
  input  logic              ret_empty,
  input  logic              ret_full,
  input  logic              lp_empty,
  input  logic              lp_full,
  input  logic [ADDR_W-1:0] lp_first,
  input  logic [ADDR_W-1:0] lp_last,
  input  logic [CNT_W-1:0]  lp_cnt,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] seq_pc,
  output logic              ret_push,
  output logic              ret_pop,
  output logic              lp_push,
  output logic              lp_pop,
  output logic              lp_dec,
  output logic              ovf_evt,
  output logic              unf_evt,
  output logic              at_end
);

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic more_passes(input logic [CNT_W-1:0] c);
    return c > CNT_W'(1);
  endfunction

  assign seq_pc = addr_inc(pc);
  assign at_end = !lp_empty && (pc == lp_last);

  always_comb begin
    next_pc  = seq_pc;
    ret_push = 1'b0;
    ret_pop  = 1'b0;
    lp_push  = 1'b0;
    lp_pop   = 1'b0;
    lp_dec   = 1'b0;
    ovf_evt  = 1'b0;
    unf_evt  = 1'b0;
    case (op)
      OP_JUMP: begin
        if (cond) next_pc = target;
      end
      OP_CALL: begin
        if (cond) begin
          next_pc = target;
          if (ret_full) ovf_evt = 1'b1;
          else          ret_push = 1'b1;
        end
      end
      OP_RET: begin
        if (ret_empty) begin
          unf_evt = 1'b1;
        end else begin
          ret_pop = 1'b1;
          next_pc = ret_top;
        end
      end
      OP_LOOP: begin
        if (lp_full) ovf_evt = 1'b1;
        else         lp_push = 1'b1;
      end
      default: begin
        if (at_end) begin
          if (more_passes(lp_cnt)) begin
            next_pc = lp_first;
            lp_dec  = 1'b1;
          end else begin
            lp_pop = 1'b1;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
  import zol_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int CNT_W      = 14,
  parameter int RET_DEPTH  = 16,
  parameter int LOOP_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] loop_end_i,
  input  logic [CNT_W-1:0]  loop_cnt_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int LW = 2 * ADDR_W + CNT_W;

  seq_op_e           op;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] ret_top;
  logic              ret_empty, ret_full, ret_push, ret_pop;
  logic              lp_empty, lp_full, lp_push, lp_pop, lp_dec;
  logic [LW-1:0]     lp_word_top;
  logic [LW-1:0]     lp_word_in;
  logic [ADDR_W-1:0] lp_first, lp_last;
  logic [CNT_W-1:0]  lp_cnt;
  logic              ovf_evt, unf_evt, at_end;
  logic              ovf_q, unf_q;
  logic              loop_back;

  assign op        = seq_op_e'(op_i);
  assign lp_first  = lp_word_top[LW-1 -: ADDR_W];
  assign lp_last   = lp_word_top[CNT_W +: ADDR_W];
  assign lp_cnt    = lp_word_top[CNT_W-1:0];
  assign loop_back = lp_dec;
  assign lp_word_in = lp_push ? {seq_pc, loop_end_i, loop_cnt_i}
                              : {lp_first, lp_last, lp_cnt - CNT_W'(1)};

  zol_next_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_next (
    .op(op), .cond(cond_i), .pc(pc_q), .target(target_i),
    .ret_top(ret_top), .ret_empty(ret_empty), .ret_full(ret_full),
    .lp_empty(lp_empty), .lp_full(lp_full),
    .lp_first(lp_first), .lp_last(lp_last), .lp_cnt(lp_cnt),
    .next_pc(next_pc), .seq_pc(seq_pc),
    .ret_push(ret_push), .ret_pop(ret_pop),
    .lp_push(lp_push), .lp_pop(lp_pop), .lp_dec(lp_dec),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .at_end(at_end)
  );

  zol_lifo #(.W(ADDR_W), .DEPTH(RET_DEPTH)) u_ret_stack (
    .clk(clk), .rst_n(rst_n), .push_i(ret_push), .pop_i(ret_pop),
    .wr_top_i(1'b0), .data_i(seq_pc), .top_o(ret_top),
    .full_o(ret_full), .empty_o(ret_empty)
  );

  zol_lifo #(.W(LW), .DEPTH(LOOP_DEPTH)) u_loop_stack (
    .clk(clk), .rst_n(rst_n), .push_i(lp_push), .pop_i(lp_pop),
    .wr_top_i(lp_dec), .data_i(lp_word_in), .top_o(lp_word_top),
    .full_o(lp_full), .empty_o(lp_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      pc_q  <= next_pc;
      ovf_q <= ovf_q | ovf_evt;
      unf_q <= unf_q | unf_evt;
    end
  end

  assign fetch_addr_o = pc_q;
  assign ovf_o        = ovf_q;
  assign unf_o        = unf_q;

  // R2: plain step when no loop closes here
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && op == OP_SEQ && !at_end |=> fetch_addr_o == ADDR_W'($past(fetch_addr_o) + ADDR_W'(1)));

  // R3: taken jump lands on its target one cycle later
  a_r3_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && op == OP_JUMP && cond_i |=> fetch_addr_o == $past(target_i));

  // R4: return lands on the saved address
  a_r4_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && op == OP_RET && !ret_empty |=> fetch_addr_o == $past(ret_top));

  // R6: loop close goes to the stacked first address with no bubble
  a_r6_loop_back: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && loop_back |=> fetch_addr_o == $past(lp_first));

  // R8: overflow flag is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R9: underflow flag is sticky
  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> unf_o);

endmodule

// File: tb/zol_sequencer_tb_top.sv
module zol_sequencer_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic        cond_i;
  logic [13:0] target_i, loop_end_i, loop_cnt_i;
  logic [13:0] fetch_addr_o;
  logic        ovf_o, unf_o;

  logic [2:0]  pm_op   [256];
  logic        pm_cond [256];
  logic [13:0] pm_tgt  [256];
  logic [13:0] pm_end  [256];
  logic [13:0] pm_cnt  [256];

  int checks = 0;
  int errors = 0;
  int seq_q[$];

  always #(CLK_P/2) clk = ~clk;

  zol_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .cond_i(cond_i),
    .target_i(target_i), .loop_end_i(loop_end_i), .loop_cnt_i(loop_cnt_i),
    .fetch_addr_o(fetch_addr_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) begin
      pm_op[i] = 3'd0; pm_cond[i] = 1'b1; pm_tgt[i] = '0;
      pm_end[i] = '0;  pm_cnt[i] = '0;
    end
  endtask

  task automatic drive();
    int a;
    a = int'(fetch_addr_o[7:0]);
    op_i = pm_op[a]; cond_i = pm_cond[a]; target_i = pm_tgt[a];
    loop_end_i = pm_end[a]; loop_cnt_i = pm_cnt[a];
  endtask

  task automatic step();
    drive();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op_i = 3'd0; cond_i = 1'b0; target_i = '0; loop_end_i = '0; loop_cnt_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_seq(input string req);
    for (int i = 0; i < seq_q.size(); i++) begin
      chk(req, int'(fetch_addr_o), seq_q[i]);
      if (i < seq_q.size() - 1) step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    clear_prog();
    do_reset();
    chk("R1 addr", int'(fetch_addr_o), 0);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 unf", int'(unf_o), 0);

    // R2: sequential, including unused codes 5..7
    clear_prog();
    pm_op[2] = 3'd7; pm_op[3] = 3'd5; pm_op[4] = 3'd6;
    do_reset();
    seq_q = '{0, 1, 2, 3, 4, 5, 6};
    run_seq("R2");

    // R3: jump taken and not taken
    clear_prog();
    pm_op[3] = 3'd1; pm_tgt[3] = 14'd50;
    pm_op[51] = 3'd1; pm_tgt[51] = 14'd10; pm_cond[51] = 1'b0;
    do_reset();
    seq_q = '{0, 1, 2, 3, 50, 51, 52, 53};
    run_seq("R3");

    // R4: nested calls, returns, untaken call
    clear_prog();
    pm_op[2] = 3'd2;  pm_tgt[2] = 14'd20;
    pm_op[20] = 3'd2; pm_tgt[20] = 14'd40;
    pm_op[41] = 3'd3;
    pm_op[21] = 3'd3;
    pm_op[3] = 3'd2;  pm_tgt[3] = 14'd90; pm_cond[3] = 1'b0;
    pm_op[5] = 3'd3;
    do_reset();
    seq_q = '{0, 1, 2, 20, 40, 41, 21, 3, 4, 5, 6};
    run_seq("R4");
    chk("R4 untaken call saved nothing (unf)", int'(unf_o), 1);

    // R5/R6: sweep count x body length
    for (int n = 1; n <= 4; n++) begin
      for (int l = 1; l <= 3; l++) begin
        clear_prog();
        pm_op[1] = 3'd4; pm_end[1] = 14'(1 + l); pm_cnt[1] = 14'(n);
        do_reset();
        step();
        step();
        for (int k = 0; k <= n * l; k++) begin
          int exp;
          exp = (k < n * l) ? 2 + (k % l) : 2 + l;
          chk($sformatf("R6 n=%0d l=%0d k=%0d", n, l, k), int'(fetch_addr_o), exp);
          step();
        end
        chk("R5 no flags", int'(ovf_o | unf_o), 0);
      end
    end

    // R6: count of zero runs once
    clear_prog();
    pm_op[1] = 3'd4; pm_end[1] = 14'd3; pm_cnt[1] = 14'd0;
    do_reset();
    seq_q = '{0, 1, 2, 3, 4, 5};
    run_seq("R6 zero count");

    // R7: nested loops
    clear_prog();
    pm_op[1] = 3'd4; pm_end[1] = 14'd6; pm_cnt[1] = 14'd2;
    pm_op[3] = 3'd4; pm_end[3] = 14'd4; pm_cnt[3] = 14'd3;
    do_reset();
    seq_q = '{0, 1, 2, 3, 4, 4, 4, 5, 6, 2, 3, 4, 4, 4, 5, 6, 7, 8};
    run_seq("R7");

    // R8: return stack overflow on 17th call
    clear_prog();
    for (int k = 0; k <= 16; k++) begin
      pm_op[k] = 3'd2; pm_tgt[k] = 14'(k + 1);
    end
    pm_op[17] = 3'd3;
    do_reset();
    for (int k = 0; k < 16; k++) step();
    chk("R8 addr after 16 calls", int'(fetch_addr_o), 16);
    chk("R8 no ovf at 16", int'(ovf_o), 0);
    step();
    chk("R8 target taken on overflow", int'(fetch_addr_o), 17);
    chk("R8 ovf set", int'(ovf_o), 1);
    step();
    chk("R8 top kept after dropped push", int'(fetch_addr_o), 16);
    chk("R8 ovf sticky", int'(ovf_o), 1);
    do_reset();
    chk("R1 reset clears ovf", int'(ovf_o), 0);

    // R9: return on empty stack
    clear_prog();
    pm_op[0] = 3'd3;
    do_reset();
    step();
    chk("R9 addr", int'(fetch_addr_o), 1);
    chk("R9 unf set", int'(unf_o), 1);
    step(); step();
    chk("R9 unf sticky", int'(unf_o), 1);
    chk("R9 ovf clear", int'(ovf_o), 0);

    // R10: loop stack overflow on 5th loop start
    clear_prog();
    for (int k = 0; k <= 4; k++) begin
      pm_op[k] = 3'd4; pm_end[k] = 14'd200; pm_cnt[k] = 14'd3;
    end
    pm_op[10] = 3'd4; pm_end[10] = 14'd11; pm_cnt[10] = 14'd2;
    do_reset();
    for (int k = 0; k < 4; k++) step();
    chk("R10 no ovf at 4", int'(ovf_o), 0);
    step();
    chk("R10 ovf set", int'(ovf_o), 1);
    chk("R10 addr advanced", int'(fetch_addr_o), 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule